// File: doc/BRIEF.md
# MDIO Management Master

This block runs clause 22 management transactions on a two-wire PHY management bus. Software programs a command register with the PHY address, the PHY register number and the direction. For a write it also loads sixteen bits of write data. It then sets the start bit in the control register. The block sends a preamble and the frame on MDIO, timed to a management clock (MDC) that it derives from the system clock. For reads it releases the line at the turnaround and shifts in the PHY's sixteen data bits. When the frame ends it clears the start bit, which software polls as a busy flag.

Four word registers sit on a simple synchronous write and combinational read port, at offsets 0x7E4 (command), 0x7E8 (write data), 0x7EC (read data) and 0x7F0 (control). The MDIO pin is split into an output value, an output enable and a registered-domain input, so that the pad ring can build the tri-state buffer. `mdio_i` is taken to be synchronous to `clk`.

Top module: `mdio_mgmt_master`

## Requirements
- R1: The command register at 0x7E4 holds bits 10:0 and reads them back, with upper bits 0: bits 4:0 are the PHY register number, bits 9:5 the PHY address, and bit 10 the direction (1 = read, 0 = write).
- R2: The write data register at 0x7E8 holds and reads back 16 bits.
- R3: MDC starts low after reset and toggles every HALF system clocks, where HALF = ceil(CLK_HZ / (2 * MDC_MAX_HZ)) (20 by default), so MDC never exceeds MDC_MAX_HZ.
- R4: Each frame is driven MSB first as 32 ones, start bits 0 then 1, opcode 1,0 for read or 0,1 for write, 5 PHY address bits, then 5 register bits; the first bit appears at the first falling MDC after the start.
- R5: A write frame then drives the turnaround 1,0 and the 16 write data bits, MSB first.
- R6: A read frame releases MDIO (output enable low) for the two turnaround bits and the 16 data bits, samples the data on the rising MDC edges, MSB first, and places the result in bits 15:0 of the read data register at 0x7EC when the frame ends.
- R7: A read from an absent PHY, whose line floats high, returns 0xFFFF.
- R8: The MDIO output value and output enable change only together with a falling MDC edge.
- R9: Control register (0x7F0) bit 0 reads 1 from the cycle after an accepted start until the falling MDC that ends the 64th bit, then 0. Bit 3 is the enable and reads back as written.
- R10: A start request is ignored when the enable bit, as written by that same control write, is 0.
- R11: A start request while a frame is running is ignored, and writes to the command or write data registers during a frame do not change that frame.
- R12: The output enable is low whenever no frame is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 12 | Register byte offset |
| bus_wdata | input | 16 | Register write data |
| bus_rdata | output | 16 | Register read data for bus_addr |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO input value |

## Verification
The hardest case to reach is a second start request, together with new command and write data values, that arrives while a frame is already on the wire. The bench starts a write and waits a few hundred cycles into the preamble. It then rewrites the command, the write data and the control start bit. Its model keeps the expected bit queue built at the first start, so any leak of the new values shows up as a bit mismatch, and any extra frame shows up as a busy flag or an enabled output after completion. A PHY model drives known read data only during the read data bits and lets the line float high otherwise, which covers the absent-PHY case.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;
  localparam int REG_W      = 16;
  localparam int FIELD_W    = 5;
  localparam int CMD_W      = 2 * FIELD_W + 1;
  localparam int PRE_BITS   = 32;
  localparam int FRAME_BITS = PRE_BITS + 2 + 2 + 2 * FIELD_W + 2 + REG_W;
  localparam int IDX_W      = $clog2(FRAME_BITS);
  localparam int TA_FIRST   = FRAME_BITS - REG_W - 2;
  localparam int DATA_FIRST = FRAME_BITS - REG_W;

  typedef enum logic [1:0] {ENG_IDLE, ENG_WAIT, ENG_SHIFT} eng_state_t;

  typedef struct packed {
    logic               rd;
    logic [FIELD_W-1:0] phy;
    logic [FIELD_W-1:0] regn;
  } mdio_cmd_t;

  function automatic int mdc_half(input int clk_hz, input int mdc_hz);
    return (clk_hz + 2 * mdc_hz - 1) / (2 * mdc_hz);
  endfunction

  function automatic logic [FRAME_BITS-1:0] mdio_frame(input mdio_cmd_t cmd,
                                                      input logic [REG_W-1:0] wd);
    logic [1:0]       op;
    logic [1:0]       ta;
    logic [REG_W-1:0] dat;
    op  = cmd.rd ? 2'b10 : 2'b01;
    ta  = cmd.rd ? 2'b00 : 2'b10;
    dat = cmd.rd ? '0 : wd;
    return {{PRE_BITS{1'b1}}, 2'b01, op, cmd.phy, cmd.regn, ta, dat};
  endfunction

  function automatic logic mdio_drives(input logic rd, input logic [IDX_W-1:0] idx);
    return !(rd && (int'(idx) >= TA_FIRST));
  endfunction
endpackage

// File: rtl/mdio_clk_div.sv
module mdio_clk_div #(
  parameter int HALF = 20
) (
  input  logic clk,
  input  logic rst_n,
  output logic mdc,
  output logic rise_stb,
  output logic fall_stb
);
  localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;

  logic [CW-1:0] cnt;
  logic          wrap;

  assign wrap     = (cnt == CW'(HALF - 1));
  assign rise_stb = wrap & ~mdc;
  assign fall_stb = wrap & mdc;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (wrap) begin
      cnt <= '0;
      mdc <= ~mdc;
    end else begin
      cnt <= cnt + CW'(1);
    end
  end
endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
  import mdio_mgmt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  mdio_cmd_t         cmd,
  input  logic [REG_W-1:0]  wdata,
  input  logic              rise_stb,
  input  logic              fall_stb,
  input  logic              mdio_i,
  output logic              mdio_o,
  output logic              mdio_oe,
  output logic              busy,
  output logic              done,
  output logic              rd_op,
  output logic [IDX_W-1:0]  bit_idx,
  output logic [REG_W-1:0]  rdata
);
  eng_state_t              st;
  logic [FRAME_BITS-1:0]   frame;
  logic [IDX_W-1:0]        idx;
  logic [IDX_W-1:0]        idx_nx;
  logic                    rd;
  logic [REG_W-1:0]        cap;
  logic                    last_bit;

  assign idx_nx   = idx + IDX_W'(1);
  assign last_bit = (idx == IDX_W'(FRAME_BITS - 1));
  assign busy     = (st != ENG_IDLE);
  assign done     = (st == ENG_SHIFT) && fall_stb && last_bit;
  assign rd_op    = rd;
  assign bit_idx  = idx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= ENG_IDLE;
      frame   <= '0;
      idx     <= '0;
      rd      <= 1'b0;
      cap     <= '0;
      rdata   <= '0;
      mdio_o  <= 1'b1;
      mdio_oe <= 1'b0;
    end else begin
      case (st)
        ENG_IDLE: begin
          if (start) begin
            st    <= ENG_WAIT;
            frame <= mdio_frame(cmd, wdata);
            rd    <= cmd.rd;
            idx   <= '0;
          end
        end
        ENG_WAIT: begin
          if (fall_stb) begin
            st      <= ENG_SHIFT;
            mdio_o  <= frame[FRAME_BITS-1];
            mdio_oe <= 1'b1;
            idx     <= '0;
          end
        end
        ENG_SHIFT: begin
          if (fall_stb) begin
            if (last_bit) begin
              st      <= ENG_IDLE;
              mdio_oe <= 1'b0;
              rdata   <= cap;
            end else begin
              idx     <= idx_nx;
              mdio_o  <= frame[FRAME_BITS-2];
              frame   <= {frame[FRAME_BITS-2:0], 1'b0};
              mdio_oe <= mdio_drives(rd, idx_nx);
            end
          end
          if (rise_stb && rd && (int'(idx) >= DATA_FIRST))
            cap <= {cap[REG_W-2:0], mdio_i};
        end
        default: st <= ENG_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mdio_csr.sv
module mdio_csr
  import mdio_mgmt_pkg::*;
#(
  parameter int              BUS_AW   = 12,
  parameter logic [11:0]     OFF_CMD  = 12'h7E4,
  parameter logic [11:0]     OFF_WD   = 12'h7E8,
  parameter logic [11:0]     OFF_RD   = 12'h7EC,
  parameter logic [11:0]     OFF_CTRL = 12'h7F0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  input  logic              busy,
  input  logic [REG_W-1:0]  rd_result,
  output mdio_cmd_t         cmd,
  output logic [REG_W-1:0]  wdata,
  output logic              start,
  output logic              en
);
  localparam int EN_BIT = 3;

  logic [CMD_W-1:0] cmd_q;
  logic [REG_W-1:0] wd_q;
  logic             en_q;
  logic             hit_ctrl;

  assign hit_ctrl = bus_we && (bus_addr == BUS_AW'(OFF_CTRL));
  assign start    = hit_ctrl && bus_wdata[0] && bus_wdata[EN_BIT] && !busy;
  assign cmd      = mdio_cmd_t'(cmd_q);
  assign wdata    = wd_q;
  assign en       = en_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q <= '0;
      wd_q  <= '0;
      en_q  <= 1'b0;
    end else if (bus_we) begin
      if (bus_addr == BUS_AW'(OFF_CMD)) cmd_q <= bus_wdata[CMD_W-1:0];
      if (bus_addr == BUS_AW'(OFF_WD))  wd_q  <= bus_wdata;
      if (hit_ctrl)                     en_q  <= bus_wdata[EN_BIT];
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == BUS_AW'(OFF_CMD))  bus_rdata = REG_W'(cmd_q);
    if (bus_addr == BUS_AW'(OFF_WD))   bus_rdata = wd_q;
    if (bus_addr == BUS_AW'(OFF_RD))   bus_rdata = rd_result;
    if (bus_addr == BUS_AW'(OFF_CTRL)) begin
      bus_rdata[0]      = busy;
      bus_rdata[EN_BIT] = en_q;
    end
  end
endmodule

// File: rtl/mdio_mgmt_master.sv
module mdio_mgmt_master
  import mdio_mgmt_pkg::*;
#(
  parameter int CLK_HZ     = 100_000_000,
  parameter int MDC_MAX_HZ = 2_500_000,
  parameter int BUS_AW     = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic [15:0]       bus_wdata,
  output logic [15:0]       bus_rdata,
  output logic              mdc,
  output logic              mdio_o,
  output logic              mdio_oe,
  input  logic              mdio_i
);
  localparam int HALF = mdc_half(CLK_HZ, MDC_MAX_HZ);

  logic             mdc_rise;
  logic             mdc_fall;
  logic             start_acc;
  logic             csr_en;
  mdio_cmd_t        cmd;
  logic [REG_W-1:0] cmd_wdata;
  logic [REG_W-1:0] rd_result;
  logic             eng_busy;
  logic             eng_done;
  logic             eng_rd;
  logic [IDX_W-1:0] eng_idx;

  mdio_clk_div #(.HALF(HALF)) u_div (
    .clk(clk), .rst_n(rst_n), .mdc(mdc), .rise_stb(mdc_rise), .fall_stb(mdc_fall)
  );

  mdio_csr #(.BUS_AW(BUS_AW)) u_csr (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .busy(eng_busy),
    .rd_result(rd_result), .cmd(cmd), .wdata(cmd_wdata), .start(start_acc),
    .en(csr_en)
  );

  mdio_frame_engine u_eng (
    .clk(clk), .rst_n(rst_n), .start(start_acc), .cmd(cmd), .wdata(cmd_wdata),
    .rise_stb(mdc_rise), .fall_stb(mdc_fall), .mdio_i(mdio_i), .mdio_o(mdio_o),
    .mdio_oe(mdio_oe), .busy(eng_busy), .done(eng_done), .rd_op(eng_rd),
    .bit_idx(eng_idx), .rdata(rd_result)
  );
endmodule

// File: rtl/mdio_mgmt_master_chk.sv
module mdio_mgmt_master_chk
  import mdio_mgmt_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             mdc,
  input logic             mdio_o,
  input logic             mdio_oe,
  input logic             busy,
  input logic             done,
  input logic             start,
  input logic             rise_stb,
  input logic             fall_stb,
  input logic             rd_op,
  input logic             en,
  input logic [IDX_W-1:0] bit_idx
);
  AST_MDC_RISE: assert property (@(posedge clk) disable iff (!rst_n) rise_stb |=> mdc); // R3
  AST_MDC_FALL: assert property (@(posedge clk) disable iff (!rst_n) fall_stb |=> !mdc); // R3
  AST_PIN_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(mdio_o) || !$stable(mdio_oe)) |-> $fell(mdc)); // R8
  AST_READ_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && rd_op && (int'(bit_idx) >= TA_FIRST)) |-> !mdio_oe); // R6
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> !mdio_oe); // R12
  AST_START_IDLE: assert property (@(posedge clk) disable iff (!rst_n) start |-> !busy); // R11
  AST_START_EN: assert property (@(posedge clk) disable iff (!rst_n) start |=> en); // R10
  AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) done |=> !busy); // R9
  AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) (busy && !done) |=> busy); // R9
endmodule

bind mdio_mgmt_master mdio_mgmt_master_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
  .busy(eng_busy), .done(eng_done), .start(start_acc), .rise_stb(mdc_rise),
  .fall_stb(mdc_fall), .rd_op(eng_rd), .en(csr_en), .bit_idx(eng_idx)
);

// File: tb/mdio_mgmt_master_bench.sv
module mdio_mgmt_master_bench;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 100_000_000 / (2 * 2_500_000);
  localparam logic [11:0] A_CMD  = 12'h7E4;
  localparam logic [11:0] A_WD   = 12'h7E8;
  localparam logic [11:0] A_RD   = 12'h7EC;
  localparam logic [11:0] A_CTRL = 12'h7F0;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [11:0] bus_addr = A_CTRL;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        mdc, mdio_o, mdio_oe, mdio_i;

  int n_checks = 0;
  int n_fail = 0;

  // reference model state
  int          cyc;
  bit          m_mdc, m_busy, m_en, m_rd, m_oe, m_o;
  bit          q_bit[$];
  bit          q_oe[$];
  int          popped;
  logic [15:0] m_cap, m_rdreg, m_wd;
  logic [10:0] m_cmd;
  bit          phy_present = 1'b0;
  logic [15:0] phy_word = '0;
  bit          prev_mdc, rise_e, fall_e, old_busy;

  always #(CLK_PERIOD / 2) clk = ~clk;

  mdio_mgmt_master u_mdio_mgmt_master (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mdc(mdc), .mdio_o(mdio_o),
    .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  assign mdio_i = mdio_oe ? mdio_o :
                  (phy_present && m_busy && m_rd && popped >= 49) ? phy_word[15 - (popped - 49)] :
                  1'b1;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic push_bits(input logic [15:0] v, input int n, input bit oe);
    for (int i = n - 1; i >= 0; i--) begin
      q_bit.push_back(v[i]);
      q_oe.push_back(oe);
    end
  endtask

  task automatic load_frame();
    q_bit.delete();
    q_oe.delete();
    m_rd = m_cmd[10];
    for (int i = 0; i < 32; i++) begin q_bit.push_back(1'b1); q_oe.push_back(1'b1); end
    push_bits(16'b01, 2, 1'b1);
    push_bits(m_rd ? 16'b10 : 16'b01, 2, 1'b1);
    push_bits({11'd0, m_cmd[9:5]}, 5, 1'b1);
    push_bits({11'd0, m_cmd[4:0]}, 5, 1'b1);
    if (m_rd) begin
      push_bits(16'b00, 2, 1'b0);
      push_bits(16'h0, 16, 1'b0);
    end else begin
      push_bits(16'b10, 2, 1'b1);
      push_bits(m_wd, 16, 1'b1);
    end
    popped = 0;
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      cyc = 0; m_mdc = 0; m_busy = 0; m_en = 0; m_rd = 0; m_oe = 0; m_o = 1;
      m_cap = 0; m_rdreg = 0; m_wd = 0; m_cmd = 0; popped = 0;
      q_bit.delete(); q_oe.delete();
    end else begin
      old_busy = m_busy;
      prev_mdc = m_mdc;
      cyc++;
      if (cyc % HALF == 0) m_mdc = ~m_mdc;
      rise_e = !prev_mdc && m_mdc;
      fall_e = prev_mdc && !m_mdc;
      if (rise_e && old_busy && m_rd && popped >= 49) m_cap = {m_cap[14:0], mdio_i};
      if (fall_e && old_busy) begin
        if (q_bit.size() > 0) begin
          m_o = q_bit.pop_front();
          m_oe = q_oe.pop_front();
          popped++;
        end else if (popped == 64) begin
          m_busy = 0;
          m_oe = 0;
          m_rdreg = m_cap;
        end
      end
      if (bus_we) begin
        if (bus_addr == A_CMD) m_cmd = bus_wdata[10:0];
        if (bus_addr == A_WD) m_wd = bus_wdata;
        if (bus_addr == A_CTRL) begin
          m_en = bus_wdata[3];
          if (bus_wdata[0] && bus_wdata[3] && !old_busy) begin
            m_busy = 1;
            load_frame();
          end
        end
      end
    end
  end

  // every-clock comparison against the model
  logic last_o, last_oe, last_mdc;
  always @(negedge clk) begin
    if (rst_n) begin
      check(mdc == m_mdc, "R3", {31'd0, mdc}, {31'd0, m_mdc});
      check(mdio_oe == m_oe, (m_rd && popped > 46) ? "R6" : "R12", {31'd0, mdio_oe}, {31'd0, m_oe});
      if (m_oe)
        check(mdio_o == m_o, (!m_rd && popped > 46) ? "R5" : "R4", {31'd0, mdio_o}, {31'd0, m_o});
      if (bus_addr == A_CTRL) begin
        check(bus_rdata[0] == m_busy, "R9", {31'd0, bus_rdata[0]}, {31'd0, m_busy});
        check(bus_rdata[3] == m_en, "R9", {31'd0, bus_rdata[3]}, {31'd0, m_en});
      end
      if (mdio_o !== last_o || mdio_oe !== last_oe)
        check(last_mdc && !mdc, "R8", {30'd0, last_mdc, mdc}, 32'h2);
    end
    last_o = mdio_o;
    last_oe = mdio_oe;
    last_mdc = mdc;
  end

  task automatic wr(input logic [11:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0; bus_addr = A_CTRL;
  endtask

  task automatic rd(input logic [11:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_addr = A_CTRL;
  endtask

  task automatic wait_idle();
    while (m_busy) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150_000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    logic [15:0] v;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    // reset state
    rd(A_CMD, v);  check(v == 16'h0, "R1", v, 16'h0);
    rd(A_WD, v);   check(v == 16'h0, "R2", v, 16'h0);
    rd(A_RD, v);   check(v == 16'h0, "R6", v, 16'h0);
    check(mdio_oe == 1'b0, "R12", {31'd0, mdio_oe}, 32'd0);
    // register readback
    wr(A_CMD, 16'hFFFF); rd(A_CMD, v); check(v == 16'h07FF, "R1", v, 16'h07FF);
    wr(A_WD, 16'hBEEF);  rd(A_WD, v);  check(v == 16'hBEEF, "R2", v, 16'hBEEF);
    // start with enable low is ignored
    wr(A_CTRL, 16'h0001);
    repeat (4 * HALF) @(negedge clk);
    rd(A_CTRL, v); check(v == 16'h0000, "R10", v, 16'h0000);
    check(mdio_oe == 1'b0, "R10", {31'd0, mdio_oe}, 32'd0);
    // write frame
    wr(A_CMD, 16'h00A3);
    wr(A_WD, 16'hA5C3);
    wr(A_CTRL, 16'h0009);
    check(bus_rdata[0] == 1'b1, "R9", {31'd0, bus_rdata[0]}, 32'd1);
    wait_idle();
    rd(A_CTRL, v); check(v == 16'h0008, "R9", v, 16'h0008);
    // read frame with PHY present
    phy_present = 1'b1; phy_word = 16'h1234;
    wr(A_CMD, 16'h0421);
    wr(A_CTRL, 16'h0009);
    wait_idle();
    rd(A_RD, v); check(v == 16'h1234, "R6", v, 16'h1234);
    check(v == m_rdreg, "R6", v, m_rdreg);
    // read frame with PHY absent
    phy_present = 1'b0;
    wr(A_CMD, 16'h07E2);
    wr(A_CTRL, 16'h0009);
    wait_idle();
    rd(A_RD, v); check(v == 16'hFFFF, "R7", v, 16'hFFFF);
    // second start and register changes during a running write frame
    wr(A_CMD, 16'h0047);
    wr(A_WD, 16'h0F0F);
    wr(A_CTRL, 16'h0009);
    repeat (200) @(negedge clk);
    wr(A_CMD, 16'h0400);
    wr(A_WD, 16'h1111);
    wr(A_CTRL, 16'h0009);
    wait_idle();
    repeat (4 * HALF) @(negedge clk);
    rd(A_CTRL, v); check(v == 16'h0008, "R11", v, 16'h0008);
    check(mdio_oe == 1'b0, "R11", {31'd0, mdio_oe}, 32'd0);
    rd(A_RD, v); check(v == 16'hFFFF, "R11", v, 16'hFFFF);
    finish_run();
  end
endmodule